// File: doc/BRIEF.md
# Match Timer with Watchdog

This block is a memory-mapped timer built around a single 32-bit up-counter. The counter moves forward by one on every cycle in which the tick-enable input is high. Software can read the counter at any time. Software can also load the counter, and counting then resumes upward from the loaded value. Four 32-bit compare registers each watch the counter. When the counter takes a value equal to a compare register, that channel can latch a sticky status flag. The flag drives the channel's interrupt line.

Software sees the block through a simple register bus with valid, write, address and data signals. Besides the compare registers and the counter, the bus reaches these registers:
- an interrupt-enable register, which gates which channels may latch status;
- a status register, cleared by writing ones to it;
- a watchdog-enable register.

When the watchdog bit is set, a compare hit on channel 3 produces a one-cycle reset request. The same hit clears the watchdog bit, so the request is issued only once per arming.

Top module: `match_timer`

## Requirements
- R1: After synchronous reset, the counter, the compare registers, status, interrupt enable and watchdog enable are all zero. The irq lines, bus_err and wdt_reset_req are low.
- R2: A write to offset 0x10 loads the counter with the write data on that clock edge. A read of 0x10 returns the current counter value.
- R3: Channel i (compare register at offset 4*i, for i = 0..3) hits when the counter equals it. A hit sets status bit i, and with it irq[i], on the next clock edge, but only if interrupt-enable bit i is set. Status is read at offset 0x14 with bit i for channel i.
- R4: A write to 0x14 clears each status bit (and its irq line) written as 1. Bits written as 0 are unchanged. A new hit on the same edge as a clear leaves that bit set.
- R5: The interrupt-enable register at 0x1C stores only write bits 11:0. A read of 0x1C returns those 12 bits with the upper bits zero.
- R6: The watchdog-enable register at 0x18 holds bit 0. A channel-3 hit while that bit is 1 pulses wdt_reset_req high for exactly one cycle and clears the bit. This happens regardless of interrupt enable.
- R7: An access to an offset that is not word aligned, or that lies above 0x20, returns bus_err high in the following cycle. A mapped access returns bus_err low.
- R8: The counter increments by one per cycle of tick_en and wraps from 0xFFFFFFFF to 0. A load takes priority over a tick in the same cycle.
- R9: A hit is only recognised in the cycle after the counter was ticked or loaded. A counter resting on a compare value does not set status again after the status is cleared.
- R10: Read data appears on bus_rdata in the cycle after the read request and is zero in every other cycle. Offset 0x20 is a snapshot location that always reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Count enable, one increment per high cycle |
| bus_valid | input | 1 | Register access request |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| bus_err | output | 1 | Error response for an unmapped offset, the cycle after the access |
| irq | output | 4 | Per-channel interrupt lines (status bits) |
| wdt_reset_req | output | 1 | One-cycle system reset request from the watchdog |

## Verification
The hardest situation to reach is a counter that lands on a compare value and then stays there. This separates "equal" from "became equal". To reach it, the bench ticks the counter onto a compare value and stops ticking. It then clears the status and idles for several cycles, watching that the interrupt does not return. The watchdog case needs a channel-3 hit with its interrupt disabled, followed by a second hit after the bit has cleared itself. The bench loads the counter just below the channel-3 compare value twice and ticks across it. The partial-clear case needs two channels pending at once, so the bench arranges two hits before it writes a single-bit clear mask.

// File: rtl/mtmr_pkg.sv
package mtmr_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 8;
    localparam int N_CH   = 4;
    localparam int CH_W   = 2;
    localparam int IEN_W  = 12;
    localparam int WDOG_CH = 3;

    localparam logic [ADDR_W-1:0] OFS_COUNT  = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_STATUS = 8'h14;
    localparam logic [ADDR_W-1:0] OFS_WDOG   = 8'h18;
    localparam logic [ADDR_W-1:0] OFS_IEN    = 8'h1C;
    localparam logic [ADDR_W-1:0] OFS_SNAP   = 8'h20;

    typedef enum logic [2:0] {
        RS_NONE,
        RS_MATCH,
        RS_COUNT,
        RS_STATUS,
        RS_WDOG,
        RS_IEN,
        RS_SNAP
    } reg_sel_e;

    typedef struct packed {
        reg_sel_e         sel;
        logic [CH_W-1:0]  ch;
    } reg_dec_t;

    typedef struct packed {
        logic              valid;
        logic              write;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } bus_req_t;

    function automatic reg_dec_t decode_addr(input logic [ADDR_W-1:0] a);
        reg_dec_t d;
        d.ch  = a[CH_W+1:2];
        d.sel = RS_NONE;
        if (a[1:0] == 2'b00) begin
            if (a < OFS_COUNT)        d.sel = RS_MATCH;
            else if (a == OFS_COUNT)  d.sel = RS_COUNT;
            else if (a == OFS_STATUS) d.sel = RS_STATUS;
            else if (a == OFS_WDOG)   d.sel = RS_WDOG;
            else if (a == OFS_IEN)    d.sel = RS_IEN;
            else if (a == OFS_SNAP)   d.sel = RS_SNAP;
        end
        return d;
    endfunction

endpackage

// File: rtl/mtmr_counter.sv
module mtmr_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick_en,
    input  logic         load_en,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] cnt_q,
    output logic         moved_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            moved_q <= 1'b0;
        end else begin
            moved_q <= load_en | tick_en;
            if (load_en) begin
                cnt_q <= load_val;
            end else if (tick_en) begin
                cnt_q <= cnt_q + W'(1);
            end
        end
    end

endmodule

// File: rtl/mtmr_compare.sv
module mtmr_compare #(
    parameter int W = 32,
    parameter int N = 4
) (
    input  logic                  moved,
    input  logic [W-1:0]          cnt,
    input  logic [N-1:0][W-1:0]   match_vals,
    output logic [N-1:0]          hit
);

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hit[g] = moved && (cnt == match_vals[g]);
    end

endmodule

// File: rtl/mtmr_regbank.sv
module mtmr_regbank
    import mtmr_pkg::*;
#(
    parameter int W = DATA_W,
    parameter int N = N_CH
) (
    input  logic                 clk,
    input  logic                 rst,
    input  bus_req_t             req,
    input  logic [W-1:0]         cnt,
    input  logic [N-1:0]         hit,
    output logic [N-1:0][W-1:0]  match_vals,
    output logic                 load_en,
    output logic [W-1:0]         load_val,
    output logic [N-1:0]         status_q,
    output logic [IEN_W-1:0]     ien_q,
    output logic [W-1:0]         rdata_q,
    output logic                 err_q,
    output logic                 wdt_req_q
);

    reg_dec_t      dec;
    logic          wr_acc;
    logic          rd_acc;
    logic          wdog_q;
    logic          wdog_fire;
    logic [N-1:0]  clr_mask;
    logic [N-1:0]  status_d;
    logic [W-1:0]  rd_mux;

    assign dec    = decode_addr(req.addr);
    assign wr_acc = req.valid && req.write;
    assign rd_acc = req.valid && !req.write;

    assign load_en  = wr_acc && (dec.sel == RS_COUNT);
    assign load_val = req.data;

    // compare registers, one per channel
    for (genvar g = 0; g < N; g++) begin : g_match
        always_ff @(posedge clk) begin
            if (rst) begin
                match_vals[g] <= '0;
            end else if (wr_acc && dec.sel == RS_MATCH && dec.ch == CH_W'(g)) begin
                match_vals[g] <= req.data;
            end
        end
    end

    // sticky status: new enabled hits win over a simultaneous clear
    assign clr_mask  = (wr_acc && dec.sel == RS_STATUS) ? req.data[N-1:0] : '0;
    assign status_d  = (status_q & ~clr_mask) | (hit & ien_q[N-1:0]);
    assign wdog_fire = hit[WDOG_CH] && wdog_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q  <= '0;
            ien_q     <= '0;
            wdog_q    <= 1'b0;
            wdt_req_q <= 1'b0;
        end else begin
            status_q  <= status_d;
            wdt_req_q <= wdog_fire;
            if (wr_acc && dec.sel == RS_IEN) begin
                ien_q <= req.data[IEN_W-1:0];
            end
            if (wdog_fire) begin
                wdog_q <= 1'b0;
            end else if (wr_acc && dec.sel == RS_WDOG) begin
                wdog_q <= req.data[0];
            end
        end
    end

    always_comb begin
        rd_mux = '0;
        case (dec.sel)
            RS_MATCH:  rd_mux = match_vals[dec.ch];
            RS_COUNT:  rd_mux = cnt;
            RS_STATUS: rd_mux = W'(status_q);
            RS_WDOG:   rd_mux = W'(wdog_q);
            RS_IEN:    rd_mux = W'(ien_q);
            default:   rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
            err_q   <= 1'b0;
        end else begin
            rdata_q <= (rd_acc && dec.sel != RS_NONE) ? rd_mux : '0;
            err_q   <= req.valid && (dec.sel == RS_NONE);
        end
    end

endmodule

// File: rtl/match_timer.sv
module match_timer
    import mtmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [7:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_err,
    output logic [3:0]        irq,
    output logic              wdt_reset_req
);

    bus_req_t                     req;
    logic [DATA_W-1:0]            cnt_q;
    logic                         moved_q;
    logic                         load_en;
    logic [DATA_W-1:0]            load_val;
    logic [N_CH-1:0][DATA_W-1:0]  match_vals;
    logic [N_CH-1:0]              hit_vec;
    logic [N_CH-1:0]              status_q;
    logic [IEN_W-1:0]             ien_q;

    assign req.valid = bus_valid;
    assign req.write = bus_write;
    assign req.addr  = bus_addr;
    assign req.data  = bus_wdata;

    mtmr_counter #(.W(DATA_W)) u_counter (
        .clk      (clk),
        .rst      (rst),
        .tick_en  (tick_en),
        .load_en  (load_en),
        .load_val (load_val),
        .cnt_q    (cnt_q),
        .moved_q  (moved_q)
    );

    mtmr_compare #(.W(DATA_W), .N(N_CH)) u_compare (
        .moved      (moved_q),
        .cnt        (cnt_q),
        .match_vals (match_vals),
        .hit        (hit_vec)
    );

    mtmr_regbank #(.W(DATA_W), .N(N_CH)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .req        (req),
        .cnt        (cnt_q),
        .hit        (hit_vec),
        .match_vals (match_vals),
        .load_en    (load_en),
        .load_val   (load_val),
        .status_q   (status_q),
        .ien_q      (ien_q),
        .rdata_q    (bus_rdata),
        .err_q      (bus_err),
        .wdt_req_q  (wdt_reset_req)
    );

    assign irq = status_q;

endmodule

// File: rtl/mtmr_checker.sv
module mtmr_checker (
    input logic        clk,
    input logic        rst,
    input logic        tick_en,
    input logic        bus_valid,
    input logic        bus_write,
    input logic [7:0]  bus_addr,
    input logic [31:0] bus_wdata,
    input logic [31:0] bus_rdata,
    input logic        bus_err,
    input logic [3:0]  irq,
    input logic        wdt_reset_req,
    input logic [31:0] cnt_q,
    input logic [3:0]  hit_vec,
    input logic [11:0] ien_q
);

    logic is_load;
    logic is_stat_wr;
    logic mapped;

    assign is_load    = bus_valid && bus_write && (bus_addr == 8'h10);
    assign is_stat_wr = bus_valid && bus_write && (bus_addr == 8'h14);
    assign mapped     = (bus_addr[1:0] == 2'b00) && (bus_addr <= 8'h20);

    assert_load_R2: assert property (@(posedge clk) disable iff (rst)
        is_load |=> (cnt_q == $past(bus_wdata)));

    assert_count_R8: assert property (@(posedge clk) disable iff (rst)
        (tick_en && !is_load) |=> (cnt_q == 32'($past(cnt_q) + 32'd1)));

    assert_still_R9: assert property (@(posedge clk) disable iff (rst)
        (!tick_en && !is_load) |=> (hit_vec == 4'b0000));

    for (genvar g = 0; g < 4; g++) begin : g_ch
        assert_gate_R3: assert property (@(posedge clk) disable iff (rst)
            (!irq[g] && !(hit_vec[g] && ien_q[g])) |=> !irq[g]);
    end

    assert_clear_R4: assert property (@(posedge clk) disable iff (rst)
        (is_stat_wr && bus_wdata[3:0] == 4'hF && hit_vec == 4'b0000) |=> (irq == 4'b0000));

    assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (!is_stat_wr && hit_vec == 4'b0000) |=> $stable(irq));

    assert_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        wdt_reset_req |=> !wdt_reset_req);

    assert_err_R7: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && !mapped) |=> bus_err);

    assert_idle_R10: assert property (@(posedge clk) disable iff (rst)
        !bus_valid |=> (bus_rdata == 32'd0 && !bus_err));

endmodule

bind match_timer mtmr_checker u_chk (
    .clk           (clk),
    .rst           (rst),
    .tick_en       (tick_en),
    .bus_valid     (bus_valid),
    .bus_write     (bus_write),
    .bus_addr      (bus_addr),
    .bus_wdata     (bus_wdata),
    .bus_rdata     (bus_rdata),
    .bus_err       (bus_err),
    .irq           (irq),
    .wdt_reset_req (wdt_reset_req),
    .cnt_q         (cnt_q),
    .hit_vec       (hit_vec),
    .ien_q         (ien_q)
);

// File: tb/match_timer_test.sv
module match_timer_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tk = 1'b0;
    logic        v = 1'b0;
    logic        w = 1'b0;
    logic [7:0]  a = 8'h00;
    logic [31:0] d = 32'd0;
    logic [31:0] bus_rdata;
    logic        bus_err;
    logic [3:0]  irq;
    logic        wdt_reset_req;

    int checks = 0;
    int fails  = 0;

    // reference model state
    logic [31:0] m_cnt;
    logic        m_moved;
    logic [31:0] m_match [4];
    logic [3:0]  m_stat;
    logic [11:0] m_ien;
    logic        m_wdog;
    logic [31:0] m_rdata;
    logic        m_err;
    logic        m_rst;

    always #5 clk = ~clk;

    match_timer uut (
        .clk           (clk),
        .rst           (rst),
        .tick_en       (tk),
        .bus_valid     (v),
        .bus_write     (w),
        .bus_addr      (a),
        .bus_wdata     (d),
        .bus_rdata     (bus_rdata),
        .bus_err       (bus_err),
        .irq           (irq),
        .wdt_reset_req (wdt_reset_req)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_cnt = 0; m_moved = 0; m_stat = 0; m_ien = 0; m_wdog = 0;
        m_rdata = 0; m_err = 0; m_rst = 0;
        for (int i = 0; i < 4; i++) m_match[i] = 0;
    endtask

    task automatic model_edge();
        logic [3:0]  hits;
        logic [3:0]  clr;
        logic [31:0] rv;
        logic        mapped;
        for (int i = 0; i < 4; i++) hits[i] = m_moved && (m_cnt == m_match[i]);
        mapped = (a[1:0] == 2'b00) && (a <= 8'h20);
        case (a)
            8'h00, 8'h04, 8'h08, 8'h0C: rv = m_match[a[3:2]];
            8'h10: rv = m_cnt;
            8'h14: rv = {28'd0, m_stat};
            8'h18: rv = {31'd0, m_wdog};
            8'h1C: rv = {20'd0, m_ien};
            default: rv = 32'd0;
        endcase
        m_rdata = (v && !w && mapped) ? rv : 32'd0;
        m_err   = v && !mapped;
        m_rst   = hits[3] && m_wdog;
        clr     = (v && w && a == 8'h14) ? d[3:0] : 4'd0;
        m_stat  = (m_stat & ~clr) | (hits & m_ien[3:0]);
        if (m_rst) m_wdog = 0;
        else if (v && w && a == 8'h18) m_wdog = d[0];
        if (v && w && a == 8'h1C) m_ien = d[11:0];
        if (v && w && a <= 8'h0C && a[1:0] == 2'b00) m_match[a[3:2]] = d;
        if (v && w && a == 8'h10) begin
            m_cnt = d; m_moved = 1;
        end else if (tk) begin
            m_cnt = m_cnt + 32'd1; m_moved = 1;
        end else begin
            m_moved = 0;
        end
    endtask

    // one clock: model follows the edge, outputs compared at the falling edge
    task automatic cycle();
        @(negedge clk);
        if (rst) model_reset();
        else model_edge();
        chk("R3 irq vs model", {28'd0, irq}, {28'd0, m_stat});
        chk("R6 reset request vs model", {31'd0, wdt_reset_req}, {31'd0, m_rst});
        chk("R7 bus_err vs model", {31'd0, bus_err}, {31'd0, m_err});
        chk("R10 rdata vs model", bus_rdata, m_rdata);
    endtask

    task automatic wr(input logic [7:0] ad, input logic [31:0] dt);
        v = 1; w = 1; a = ad; d = dt;
        cycle();
        v = 0; w = 0; a = 0; d = 0;
    endtask

    task automatic rd(input logic [7:0] ad, input logic [31:0] exp, input string tag);
        v = 1; w = 0; a = ad;
        cycle();
        v = 0; a = 0;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic ticks(input int n);
        tk = 1;
        for (int i = 0; i < n; i++) cycle();
        tk = 0;
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) cycle();
        rst = 0;
        chk("R1 irq after reset", {28'd0, irq}, 32'd0);
        chk("R1 reset request after reset", {31'd0, wdt_reset_req}, 32'd0);
        rd(8'h10, 32'd0, "R1 counter reset");
        rd(8'h1C, 32'd0, "R1 enable reset");
        rd(8'h0C, 32'd0, "R1 compare reset");

        // R5: enable register width
        wr(8'h1C, 32'hFFFF_FFFF);
        rd(8'h1C, 32'h0000_0FFF, "R5 enable keeps 12 bits");

        // R3, R8: count onto compare 0
        wr(8'h00, 32'd3);
        wr(8'h04, 32'h100);
        wr(8'h08, 32'h200);
        wr(8'h0C, 32'h300);
        ticks(3);
        cycle();
        chk("R3 enabled hit raises irq0", {28'd0, irq}, 32'd1);
        rd(8'h14, 32'd1, "R3 status bit 0");

        // R9: resting on the compare value does not refire
        repeat (5) cycle();
        wr(8'h14, 32'h1);
        chk("R4 clear lowers irq0", {28'd0, irq}, 32'd0);
        repeat (4) cycle();
        chk("R9 no refire while still", {28'd0, irq}, 32'd0);

        // R3: disabled channel stays quiet
        wr(8'h1C, 32'h1);
        wr(8'h10, 32'hFF);
        ticks(1);
        cycle();
        chk("R3 disabled channel no irq", {28'd0, irq}, 32'd0);
        rd(8'h14, 32'd0, "R3 disabled channel no status");

        // R4: partial clear with two channels pending
        wr(8'h1C, 32'hF);
        wr(8'h10, 32'h1FF);
        ticks(1);
        wr(8'h00, 32'h201);
        ticks(1);
        cycle();
        chk("R3 two channels pending", {28'd0, irq}, 32'h5);
        wr(8'h14, 32'h4);
        chk("R4 clear only bit 2", {28'd0, irq}, 32'h1);
        wr(8'h14, 32'h0);
        chk("R4 zero write keeps status", {28'd0, irq}, 32'h1);
        wr(8'h14, 32'hF);

        // R2, R8: load and wrap
        wr(8'h10, 32'hFFFF_FFFE);
        rd(8'h10, 32'hFFFF_FFFE, "R2 load value");
        ticks(3);
        rd(8'h10, 32'd1, "R8 wrap through zero");
        tk = 1;
        wr(8'h10, 32'h50);
        tk = 0;
        rd(8'h10, 32'h50, "R8 load beats tick");

        // R6: watchdog one-shot
        wr(8'h1C, 32'h0);
        wr(8'h18, 32'h1);
        rd(8'h18, 32'd1, "R6 watchdog armed");
        wr(8'h10, 32'h2FE);
        ticks(2);
        cycle();
        chk("R6 reset pulse", {31'd0, wdt_reset_req}, 32'd1);
        cycle();
        chk("R6 pulse one cycle", {31'd0, wdt_reset_req}, 32'd0);
        rd(8'h18, 32'd0, "R6 watchdog bit cleared");
        chk("R6 no irq with enable off", {28'd0, irq}, 32'd0);
        wr(8'h10, 32'h2FF);
        ticks(1);
        cycle();
        chk("R6 no second pulse", {31'd0, wdt_reset_req}, 32'd0);

        // R7, R10: decode and error response
        rd(8'h24, 32'd0, "R7 unmapped read data");
        chk("R7 unmapped read error", {31'd0, bus_err}, 32'd1);
        rd(8'h02, 32'd0, "R7 misaligned read data");
        chk("R7 misaligned error", {31'd0, bus_err}, 32'd1);
        wr(8'h40, 32'h1234);
        chk("R7 unmapped write error", {31'd0, bus_err}, 32'd1);
        rd(8'h20, 32'd0, "R10 snapshot reads zero");
        chk("R7 mapped no error", {31'd0, bus_err}, 32'd0);
        rd(8'h0C, 32'h300, "R10 compare 3 readback");
        cycle();
        chk("R10 idle rdata zero", bus_rdata, 32'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule